// File: doc/BRIEF.md
# Programmable Write Pulse Timer

This block decides when the antenna coil drivers of a reader front end are switched off while the reader sends data to a transponder. The host drives a single data line. The block works in one of two ways, selected by a 4-bit stored pulse count. With a count of zero, the data line is passed straight through, so a high level turns the drivers off. With a non-zero count, a rising edge on the data line opens a drivers-off gap. The gap lasts exactly the stored count multiplied by a base unit, and the base unit is a fixed number of one-microsecond ticks (eight by default).

The stored count is loaded by a strobe from the command decoder and holds until the next load. A short write command therefore keeps using the count of the last full write command, and the count is zero after reset. When write mode is dropped, the drivers are back on in the same cycle and any gap in progress is abandoned. A separate coil-disable input holds the drivers off in every state.

Top module: `write_gap_timer`

## Requirements
- R1: After reset the stored count is 0, no gap is active, and `drv_off` is low whenever `coil_dis` is low.
- R2: While `wr_mode` is high and the stored count is 0, `drv_off` follows `din` in the same cycle (1 = drivers off).
- R3: While `wr_mode` is high, the stored count N is 1 to 15 and no gap is active, a rising `din` edge makes `drv_off` high from the next clock cycle. A rising edge is `din` high in a cycle where it was low in the previous cycle.
- R4: A gap ends after exactly N×UNIT_TICKS cycles in which `us_tick` is high. `drv_off` falls in the cycle after the clock edge that samples the last of those ticks.
- R5: While a gap is active, further rising edges and the level of `din` neither extend nor restart it.
- R6: After a gap ends, `drv_off` stays low while `din` stays high, until a fresh rising edge.
- R7: When `wr_mode` goes low, `drv_off` goes low in the same cycle (unless `coil_dis` is high), and any gap is cleared. Re-entering write mode with `din` already high does not start a gap.
- R8: `coil_dis` high forces `drv_off` high in every mode, with or without write mode.
- R9: A cycle with `n_wr` high stores `n_val` as the count. The count keeps its value in every other cycle, and a later load of 0 returns the block to pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mode | input | 1 | Write mode active |
| n_wr | input | 1 | Load strobe for the pulse count |
| n_val | input | 4 | Pulse count to store |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| din | input | 1 | Host data line |
| coil_dis | input | 1 | Coil-disable configuration bit |
| drv_off | output | 1 | 1 = antenna drivers off |

## Verification
Three situations are the hardest to reach from the ports: a second rising edge that lands inside an active gap, a gap that ends while `din` is still high, and a gap that is cut short by leaving write mode and then re-entering it with `din` high. The sweep runs every count from 1 to 15. Each gap gets a low-high pulse on `din` before its first tick, and odd counts keep `din` high to the end. The ticks are issued one by one with idle cycles between them, so the off level can be checked at the tick before the last and again at the last tick.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  typedef enum logic { MODE_PASS = 1'b0, MODE_GAP = 1'b1 } wpt_mode_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned r;
    r = 1;
    while ((1 << r) < n) r++;
    return r;
  endfunction
endpackage

// File: rtl/wpt_count_store.sv
module wpt_count_store #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wpt_edge_det.sv
module wpt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/wpt_gap_timer.sv
module wpt_gap_timer #(
  parameter int CNT_W      = 4,
  parameter int UNIT_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             us_tick,
  input  logic [CNT_W-1:0] units,
  output logic             active
);
  localparam int SUB_W = wpt_pkg::cnt_bits(UNIT_TICKS);
  localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(UNIT_TICKS - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] unit_q, unit_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             upd;

  always_comb begin
    act_d  = act_q;
    unit_d = unit_q;
    sub_d  = sub_q;
    if (!enable) begin
      act_d = 1'b0;
    end else if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        unit_d = units;
        sub_d  = SUB_TOP;
      end
    end else if (us_tick) begin
      if (sub_q == '0) begin
        if (unit_q <= CNT_W'(1)) begin
          act_d = 1'b0;
        end else begin
          unit_d = unit_q - CNT_W'(1);
          sub_d  = SUB_TOP;
        end
      end else begin
        sub_d = sub_q - SUB_W'(1);
      end
    end
  end

  assign upd = act_q | (enable & start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      unit_q <= '0;
      sub_q  <= '0;
    end else if (upd) begin
      act_q  <= act_d;
      unit_q <= unit_d;
      sub_q  <= sub_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/write_gap_timer.sv
module write_gap_timer #(
  parameter int CNT_W      = 4,
  parameter int UNIT_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             n_wr,
  input  logic [CNT_W-1:0] n_val,
  input  logic             us_tick,
  input  logic             din,
  input  logic             coil_dis,
  output logic             drv_off
);
  import wpt_pkg::*;

  logic [CNT_W-1:0] n_q;
  logic             din_rise;
  logic             gap_act;
  logic             gap_start;
  wpt_mode_e        mode;

  wpt_count_store #(.CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(n_wr), .val(n_val), .cnt(n_q)
  );

  wpt_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sig(din), .rise(din_rise)
  );

  assign mode      = (n_q == '0) ? MODE_PASS : MODE_GAP;
  assign gap_start = wr_mode & din_rise & (mode == MODE_GAP);

  wpt_gap_timer #(.CNT_W(CNT_W), .UNIT_TICKS(UNIT_TICKS)) u_gap (
    .clk(clk), .rst_n(rst_n), .enable(wr_mode), .start(gap_start),
    .us_tick(us_tick), .units(n_q), .active(gap_act)
  );

  always_comb begin
    drv_off = coil_dis;
    if (wr_mode) begin
      if (mode == MODE_PASS) drv_off = coil_dis | din;
      else                   drv_off = coil_dis | gap_act;
    end
  end
endmodule

// File: rtl/write_gap_timer_chk.sv
module write_gap_timer_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_mode,
  input logic             n_wr,
  input logic             us_tick,
  input logic             din,
  input logic             coil_dis,
  input logic             drv_off,
  input logic [CNT_W-1:0] n_q,
  input logic             din_rise,
  input logic             gap_act
);
  p_coil_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coil_dis |-> drv_off);

  p_idle_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && !coil_dis) |-> !drv_off);

  p_clear_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> !gap_act);

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !coil_dis && n_q == '0) |-> (drv_off == din));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && n_q != '0 && !gap_act && din_rise) |=> gap_act);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_act && wr_mode && !us_tick) |=> gap_act);

  p_count_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !n_wr |=> $stable(n_q));
endmodule

bind write_gap_timer write_gap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .n_wr(n_wr),
  .us_tick(us_tick), .din(din), .coil_dis(coil_dis), .drv_off(drv_off),
  .n_q(n_q), .din_rise(din_rise), .gap_act(gap_act)
);

// File: tb/sim_write_gap_timer.sv
module sim_write_gap_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_mode, n_wr, us_tick, din, coil_dis;
  logic [3:0] n_val;
  logic       drv_off;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  write_gap_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .n_wr(n_wr), .n_val(n_val),
    .us_tick(us_tick), .din(din), .coil_dis(coil_dis), .drv_off(drv_off)
  );

  task automatic chk(input string req, input logic exp);
    #1;
    total++;
    if (drv_off !== exp) begin
      bad++;
      $display("FAIL %s: drv_off actual=%b expected=%b", req, drv_off, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) us_tick = 1'b1;
    @(negedge clk) us_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_n(input logic [3:0] v);
    @(negedge clk) begin n_wr = 1'b1; n_val = v; end
    @(negedge clk) n_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_mode = 1'b0; n_wr = 1'b0; n_val = 4'd0;
    us_tick = 1'b0; din = 1'b0; coil_dis = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 1'b0);

    // R1/R2: stored count is 0 after reset, so write mode passes din through
    wr_mode = 1'b1;
    chk("R2 pass low", 1'b0);
    din = 1'b1;
    chk("R2 pass high", 1'b1);
    @(negedge clk) din = 1'b0;
    chk("R2 pass back low", 1'b0);

    // R8: coil disable forces off in and out of write mode
    coil_dis = 1'b1;
    chk("R8 coil in write", 1'b1);
    wr_mode = 1'b0;
    chk("R8 coil idle", 1'b1);
    coil_dis = 1'b0;
    din = 1'b1;
    chk("R7 idle din ignored", 1'b0);
    @(negedge clk) din = 1'b0;

    // R3..R6 sweep over every non-zero count
    for (int n = 1; n <= 15; n++) begin
      load_n(4'(n));
      wr_mode = 1'b1;
      @(negedge clk) din = 1'b1;
      chk("R3 no off before edge sampled", 1'b0);
      @(negedge clk);
      chk("R3 gap started", 1'b1);
      din = 1'b0;
      @(negedge clk) din = 1'b1;   // second rise inside the gap
      @(negedge clk);
      if (n % 2 == 0) din = 1'b0;
      for (int t = 1; t < n * 8; t++) tick();
      chk("R5 R4 still off before last tick", 1'b1);
      tick();
      chk("R4 gap ended after N*8 ticks", 1'b0);
      if (n % 2 == 1) begin
        repeat (3) @(negedge clk);
        chk("R6 no restart while din high", 1'b0);
      end
      @(negedge clk) begin din = 1'b0; wr_mode = 1'b0; end
    end

    // R7: leave write mode mid-gap, re-enter with din high
    load_n(4'd3);
    wr_mode = 1'b1;
    @(negedge clk) din = 1'b1;
    @(negedge clk);
    chk("R7 gap before abort", 1'b1);
    repeat (5) tick();
    wr_mode = 1'b0;
    chk("R7 immediate restore", 1'b0);
    @(negedge clk) wr_mode = 1'b1;
    chk("R7 gap cleared on reentry", 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 no gap from held din", 1'b0);

    // R9: count holds across cycles; loading 0 returns to pass-through
    @(negedge clk) begin din = 1'b0; wr_mode = 1'b0; end
    repeat (4) @(negedge clk);
    wr_mode = 1'b1;
    @(negedge clk) din = 1'b1;
    @(negedge clk);
    chk("R9 stored count kept (gap mode)", 1'b1);
    @(negedge clk) begin wr_mode = 1'b0; din = 1'b0; end
    load_n(4'd0);
    wr_mode = 1'b1;
    din = 1'b1;
    chk("R9 zero load gives pass-through", 1'b1);
    @(negedge clk) din = 1'b0;
    chk("R2 pass-through low after reload", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule